// File: doc/BRIEF.md
# Associative-Data SRAM Write Pipeline

This block sits in the command path of a search coprocessor. It turns a host write command aimed at the external associative-data SRAM into a single write cycle on the SRAM port. The host holds a write command for two cycles (first half and second half). It then keeps driving the wide data bus for two more cycles, and the block ignores what it drives there. The block decodes the command, checks the device identity and the target select, and rejects bursts. A valid write is delayed so that it leaves on the SRAM port with the same latency as a search, counted from the second command cycle.

The latency is set by a 2-bit table-size code. Code n gives a pipeline depth of 4+n cycles. A delay line holds the writes that are in flight. The upper two SRAM address bits come from spare command-bus lines, and the lower nineteen come from the data bus. Malformed writes addressed to this device are dropped and set a sticky error flag.

Top module: `sram_wr_pipe`

## Requirements
- R1: While rst_ni is low and after it is released, sram_we_no is 1, sram_drv_o is 0, sram_addr_o is 0 and err_o is 0 until a command arrives.
- R2: A write is accepted under these conditions. In cycle A, cmd_vld_i=1, cmd_i[1:0]=2'b01, dq_i[25:21] equals dev_id_i, dq_i[20:19]=2'b10 and cmd_i[2]=0. In the next cycle B, the same opcode is present with cmd_vld_i=1, select 2'b10 and cmd_i[2]=0. An accepted write produces exactly one cycle with sram_we_no=0 and sram_drv_o=1.
- R3: If cycle B has index b, the SRAM write cycle occurs in cycle b+4+tbl_size_i.
- R4: In the write cycle, sram_addr_o = {cmd_i[8:7], dq_i[18:0]}, both sampled in cycle A. In every other cycle, sram_addr_o is 0.
- R5: A write whose dq_i[25:21] differs from dev_id_i in cycle A produces no SRAM cycle and no error.
- R6: A write with cmd_i[2]=1 in cycle A or in cycle B produces no SRAM cycle and sets err_o from cycle b+1 on.
- R7: A write with dq_i[20:19] other than 2'b10 in cycle A or in cycle B produces no SRAM cycle and sets err_o from cycle b+1 on.
- R8: err_o stays 1 until reset, and later valid writes still complete.
- R9: Every command occupies four cycles. Cycle B and the two following cycles are never decoded as a new command, whatever cmd_i and dq_i carry. A new command may start in the cycle right after the fourth.
- R10: If cycle B lacks cmd_vld_i=1 with opcode 2'b01, the command is dropped silently, with no SRAM cycle and no error.
- R11: Writes issued back to back every four cycles all reach the SRAM port in order, even when two of them are in flight at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 11 | Command bus: [1:0] opcode, [2] burst, [8:7] upper SRAM address |
| cmd_vld_i | input | 1 | Command valid |
| dq_i | input | 68 | Data bus: [25:21] device ID, [20:19] target select, [18:0] lower SRAM address |
| dev_id_i | input | 5 | Identity of this device |
| tbl_size_i | input | 2 | Table-size code, sets the latency |
| sram_addr_o | output | 21 | SRAM address, valid during the write cycle |
| sram_we_no | output | 1 | SRAM write enable, active low |
| sram_drv_o | output | 1 | SRAM bus drive enable |
| err_o | output | 1 | Sticky error for a rejected write |

## Verification
A wrong command-window state shows up within four cycles. Either a write pattern inside cycles B to 4 produces an extra SRAM cycle, or a command that starts right after the window is lost. A fault in the delay line moves, duplicates or drops the write-enable pulse relative to b+4+tbl_size_i, and it may pair the pulse with the wrong address. The reference model compares every output on every clock, so such faults are caught in the cycle they occur. A wrong error-capture path is seen one cycle after cycle B, as err_o rising when it should not or staying low when it should rise.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;
  localparam int DQ_W      = 68;
  localparam int CMD_W     = 11;
  localparam int ID_W      = 5;
  localparam int LO_W      = 19;
  localparam int HI_W      = 2;
  localparam int ADDR_W    = HI_W + LO_W;
  localparam int TSZ_W     = 2;
  localparam int BASE_LAT  = 4;
  localparam int MAX_LAT   = BASE_LAT + (1 << TSZ_W) - 1;

  // field positions decoded from the host buses
  localparam int BURST_BIT = 2;
  localparam int HI_LSB    = 7;
  localparam int SEL_LSB   = 19;
  localparam int ID_LSB    = 21;

  localparam logic [1:0] OP_WR    = 2'b01;
  localparam logic [1:0] SEL_SRAM = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HALF_B,
    ST_TAIL_2,
    ST_TAIL_3
  } win_st_e;

  typedef struct packed {
    logic              vld;
    logic [ADDR_W-1:0] addr;
  } wr_slot_t;
endpackage

// File: rtl/sram_wr_cmd_fsm.sv
module sram_wr_cmd_fsm
  import sram_wr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              cmd_vld_i,
  input  logic [DQ_W-1:0]   dq_i,
  input  logic [ID_W-1:0]   dev_id_i,
  output logic              launch_o,
  output logic [ADDR_W-1:0] launch_addr_o,
  output logic              err_set_o
);
  win_st_e           st_q, st_d;
  logic              mine_q, bad_q;
  logic [ADDR_W-1:0] addr_q;

  logic is_wr, sel_bad, burst, id_hit, bad_b;
  logic unused_bits;

  assign is_wr   = cmd_vld_i && (cmd_i[1:0] == OP_WR);
  assign sel_bad = dq_i[SEL_LSB +: 2] != SEL_SRAM;
  assign burst   = cmd_i[BURST_BIT];
  assign id_hit  = dq_i[ID_LSB +: ID_W] == dev_id_i;
  assign unused_bits = ^{dq_i[DQ_W-1:ID_LSB+ID_W], cmd_i[CMD_W-1:HI_LSB+HI_W],
                         cmd_i[HI_LSB-1:BURST_BIT+1]};

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (is_wr) st_d = ST_HALF_B;
      ST_HALF_B: st_d = ST_TAIL_2;
      ST_TAIL_2: st_d = ST_TAIL_3;
      ST_TAIL_3: st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mine_q <= 1'b0;
      bad_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && is_wr) begin
        mine_q <= id_hit;
        bad_q  <= sel_bad | burst;
        addr_q <= {cmd_i[HI_LSB +: HI_W], dq_i[LO_W-1:0]};
      end
    end
  end

  // second half decides: launch, flag, or drop
  assign bad_b         = bad_q | sel_bad | burst;
  assign launch_o      = (st_q == ST_HALF_B) && mine_q && is_wr && !bad_b;
  assign err_set_o     = (st_q == ST_HALF_B) && mine_q && is_wr && bad_b;
  assign launch_addr_o = addr_q;
endmodule

// File: rtl/sram_wr_delay.sv
module sram_wr_delay
  import sram_wr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TSZ_W-1:0]  tbl_size_i,
  input  logic              in_vld_i,
  input  logic [ADDR_W-1:0] in_addr_i,
  output wr_slot_t          out_o
);
  localparam int IDX_W = $clog2(MAX_LAT);

  wr_slot_t   slot_q [MAX_LAT];
  wr_slot_t   slot_d [MAX_LAT];
  wr_slot_t   fresh;
  logic [IDX_W-1:0] ins_idx;

  // insert near the tail so the output tap stays fixed
  assign ins_idx = IDX_W'(MAX_LAT - BASE_LAT) - IDX_W'(tbl_size_i);
  assign fresh   = '{vld: 1'b1, addr: in_addr_i};

  for (genvar g = 0; g < MAX_LAT; g++) begin : g_stage
    logic hit;
    assign hit = in_vld_i && (ins_idx == IDX_W'(g));
    if (g == 0) begin : g_head
      assign slot_d[g] = hit ? fresh : '0;
    end else begin : g_body
      assign slot_d[g] = hit ? fresh : slot_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MAX_LAT; i++) slot_q[i] <= '0;
    end else begin
      for (int i = 0; i < MAX_LAT; i++) slot_q[i] <= slot_d[i];
    end
  end

  assign out_o = slot_q[MAX_LAT-1];
endmodule

// File: rtl/sram_wr_pipe.sv
module sram_wr_pipe
  import sram_wr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              cmd_vld_i,
  input  logic [DQ_W-1:0]   dq_i,
  input  logic [ID_W-1:0]   dev_id_i,
  input  logic [TSZ_W-1:0]  tbl_size_i,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_we_no,
  output logic              sram_drv_o,
  output logic              err_o
);
  logic              wr_launch;
  logic              wr_err_set;
  logic [ADDR_W-1:0] wr_addr;
  wr_slot_t          tail;
  logic              err_q;

  sram_wr_cmd_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_i        (cmd_i),
    .cmd_vld_i    (cmd_vld_i),
    .dq_i         (dq_i),
    .dev_id_i     (dev_id_i),
    .launch_o     (wr_launch),
    .launch_addr_o(wr_addr),
    .err_set_o    (wr_err_set)
  );

  sram_wr_delay u_dly (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tbl_size_i(tbl_size_i),
    .in_vld_i  (wr_launch),
    .in_addr_i (wr_addr),
    .out_o     (tail)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_q | wr_err_set;
  end

  assign sram_we_no  = ~tail.vld;
  assign sram_drv_o  = tail.vld;
  assign sram_addr_o = tail.addr;
  assign err_o       = err_q;
endmodule

// File: rtl/sram_wr_pipe_chk.sv
module sram_wr_pipe_chk
  import sram_wr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [TSZ_W-1:0]  tbl_size_i,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_we_no,
  input logic              sram_drv_o,
  input logic              err_o,
  input logic              launch_i
);
  logic [3:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= '0;
    else if (age_q != 4'hf)  age_q <= age_q + 4'd1;
  end

  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  // R2
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_drv_o |=> !sram_drv_o);

  // R2
  we_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_drv_o != sram_we_no);

  // R4
  addr_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_drv_o |-> (sram_addr_o == '0));

  // R3
  lat_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 4'd8 &&
     ((tbl_size_i == 2'd0 && $past(launch_i, 4)) ||
      (tbl_size_i == 2'd1 && $past(launch_i, 5)) ||
      (tbl_size_i == 2'd2 && $past(launch_i, 6)) ||
      (tbl_size_i == 2'd3 && $past(launch_i, 7)))) |-> sram_drv_o);

  // R3
  lat_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 4'd8 && sram_drv_o) |->
     ((tbl_size_i == 2'd0 && $past(launch_i, 4)) ||
      (tbl_size_i == 2'd1 && $past(launch_i, 5)) ||
      (tbl_size_i == 2'd2 && $past(launch_i, 6)) ||
      (tbl_size_i == 2'd3 && $past(launch_i, 7))));
endmodule

bind sram_wr_pipe sram_wr_pipe_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tbl_size_i (tbl_size_i),
  .sram_addr_o(sram_addr_o),
  .sram_we_no (sram_we_no),
  .sram_drv_o (sram_drv_o),
  .err_o      (err_o),
  .launch_i   (wr_launch)
);

// File: tb/sram_wr_pipe_test.sv
module sram_wr_pipe_test;
  import sram_wr_pkg::*;

  localparam logic [4:0] MY_ID = 5'd9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] cmd = '0;
  logic        cmd_vld = 1'b0;
  logic [67:0] dq = '0;
  logic [1:0]  tbl_size = 2'd0;
  logic [20:0] sram_addr;
  logic        sram_we_n, sram_drv, err;

  always #10 clk = ~clk;

  sram_wr_pipe uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .cmd_vld_i(cmd_vld), .dq_i(dq),
    .dev_id_i(MY_ID), .tbl_size_i(tbl_size), .sram_addr_o(sram_addr),
    .sram_we_no(sram_we_n), .sram_drv_o(sram_drv), .err_o(err)
  );

  int    cyc = 0;
  int    errs = 0;
  int    checks = 0;
  bit    run = 1'b0;
  bit    done = 1'b0;
  string tag = "R1";
  int    err_from = 1 << 30;
  int    exp_cyc[$];
  logic [20:0] exp_addr[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // reference model: expected SRAM cycles and error onset, compared every clock
  always @(negedge clk) begin
    bit want;
    logic [20:0] wa;
    if (run) begin
      want = (exp_cyc.size() > 0) && (exp_cyc[0] == cyc);
      wa   = want ? exp_addr[0] : 21'd0;
      if (want) begin
        void'(exp_cyc.pop_front());
        void'(exp_addr.pop_front());
      end
      chk(tag, "drv", 64'(sram_drv), 64'(want));
      chk(tag, "we_n", 64'(sram_we_n), 64'(!want));
      chk(tag, "addr", 64'(sram_addr), 64'(wa));
      chk(tag, "err", 64'(err), 64'(cyc >= err_from));
    end
  end

  task automatic drive(input bit v, input logic [1:0] op, input bit bst,
                       input logic [1:0] hi, input logic [4:0] id,
                       input logic [1:0] sel, input logic [18:0] lo);
    logic [10:0] c;
    logic [67:0] d;
    c = 11'($urandom);
    c[1:0] = op;
    c[2]   = bst;
    c[8:7] = hi;
    d = 68'({$urandom, $urandom, $urandom});
    d[25:21] = id;
    d[20:19] = sel;
    d[18:0]  = lo;
    cmd = c;
    dq = d;
    cmd_vld = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      drive(1'b0, 2'($urandom), 1'b0, 2'($urandom), 5'($urandom), 2'($urandom), 19'($urandom));
    end
  endtask

  task automatic wr(input logic [4:0] id, input logic [1:0] sel_a, input logic [1:0] sel_b,
                    input bit bst_a, input bit bst_b, input bit b_ok,
                    input logic [1:0] hi, input logic [18:0] lo, input bit junk);
    int e1b;
    @(negedge clk);
    drive(1'b1, OP_WR, bst_a, hi, id, sel_a, lo);
    @(negedge clk);
    drive(b_ok, b_ok ? OP_WR : 2'b11, bst_b, hi, id, sel_b, lo);
    e1b = cyc + 1;
    if (id == MY_ID && b_ok) begin
      if (bst_a || bst_b || sel_a != 2'b10 || sel_b != 2'b10) begin
        if (e1b < err_from) err_from = e1b;
      end else begin
        exp_cyc.push_back(e1b + 4 + int'(tbl_size) - 1);
        exp_addr.push_back({hi, lo});
      end
    end
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      if (junk) drive(1'b1, OP_WR, 1'b0, 2'($urandom), MY_ID, 2'b10, 19'($urandom));
      else      drive(1'($urandom), 2'($urandom), 1'($urandom), 2'($urandom),
                      5'($urandom), 2'($urandom), 19'($urandom));
    end
  endtask

  task automatic do_reset;
    @(negedge clk);
    run = 1'b0;
    rst_n = 1'b0;
    idle(3);
    chk("R1", "we_n in reset", 64'(sram_we_n), 64'd1);
    chk("R1", "drv in reset", 64'(sram_drv), 64'd0);
    chk("R1", "addr in reset", 64'(sram_addr), 64'd0);
    chk("R1", "err in reset", 64'(err), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    err_from = 1 << 30;
    tag = "R1";
    run = 1'b1;
    idle(3);
  endtask

  initial begin
    do_reset();

    tag = "R2";
    wr(MY_ID, 2'b10, 2'b10, 0, 0, 1, 2'd1, 19'h1234, 0);
    idle(10);

    tag = "R3";
    for (int t = 0; t < 4; t++) begin
      tbl_size = 2'(t);
      idle(2);
      wr(MY_ID, 2'b10, 2'b10, 0, 0, 1, 2'(t), 19'(t * 777 + 5), 0);
      idle(10);
    end
    tbl_size = 2'd0;
    idle(2);

    tag = "R4";
    wr(MY_ID, 2'b10, 2'b10, 0, 0, 1, 2'd3, 19'h7ffff, 0);
    wr(MY_ID, 2'b10, 2'b10, 0, 0, 1, 2'd0, 19'h00000, 0);
    wr(MY_ID, 2'b10, 2'b10, 0, 0, 1, 2'd2, 19'h2aaaa, 0);
    idle(10);

    tag = "R5";
    wr(5'd8, 2'b10, 2'b10, 0, 0, 1, 2'd1, 19'h111, 0);
    wr(5'd25, 2'b10, 2'b10, 1, 0, 1, 2'd1, 19'h222, 0);
    wr(5'd1, 2'b00, 2'b10, 0, 0, 1, 2'd1, 19'h333, 0);
    idle(10);

    tag = "R10";
    wr(MY_ID, 2'b10, 2'b10, 0, 0, 0, 2'd1, 19'h444, 0);
    wr(MY_ID, 2'b10, 2'b10, 1, 0, 0, 2'd1, 19'h445, 0);
    idle(10);

    tag = "R9";
    wr(MY_ID, 2'b10, 2'b10, 0, 0, 1, 2'd2, 19'h0abc, 1);
    wr(5'd3, 2'b10, 2'b10, 0, 0, 1, 2'd2, 19'h0abd, 1);
    wr(MY_ID, 2'b10, 2'b10, 0, 0, 1, 2'd1, 19'h0abe, 1);
    idle(12);

    tag = "R11";
    tbl_size = 2'd3;
    idle(2);
    for (int k = 0; k < 4; k++) wr(MY_ID, 2'b10, 2'b10, 0, 0, 1, 2'(k), 19'(k * 4099 + 1), 0);
    idle(12);
    tbl_size = 2'd0;
    idle(2);

    tag = "R6";
    wr(MY_ID, 2'b10, 2'b10, 1, 0, 1, 2'd1, 19'h501, 0);
    idle(8);
    do_reset();
    tag = "R6";
    wr(MY_ID, 2'b10, 2'b10, 0, 1, 1, 2'd1, 19'h502, 0);
    idle(8);
    do_reset();

    tag = "R7";
    wr(MY_ID, 2'b01, 2'b10, 0, 0, 1, 2'd1, 19'h601, 0);
    idle(8);
    do_reset();
    tag = "R7";
    wr(MY_ID, 2'b10, 2'b11, 0, 0, 1, 2'd1, 19'h602, 0);
    idle(8);

    tag = "R8";
    tbl_size = 2'd1;
    idle(2);
    wr(MY_ID, 2'b10, 2'b10, 0, 0, 1, 2'd2, 19'h701, 0);
    wr(MY_ID, 2'b10, 2'b10, 0, 1, 1, 2'd2, 19'h702, 0);
    wr(MY_ID, 2'b10, 2'b10, 0, 0, 1, 2'd3, 19'h703, 0);
    idle(12);
    chk("R8", "err held", 64'(err), 64'd1);
    chk("R8", "all writes seen", 64'(exp_cyc.size()), 64'd0);

    run = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL all watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule